// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block is the home authority for a group of memory lines in a multiprocessor whose nodes are linked point to point, with no shared medium that caches could watch. For every line it keeps a directory entry: a coherence state (Uncached, Shared or Exclusive) and a presence vector with one bit per node. Requesting nodes send it read-miss, write-miss and write-back requests. The controller takes one request at a time. It sends targeted invalidate, fetch or fetch-and-invalidate messages to the nodes that hold copies and waits for their acknowledgements. It then returns the line's data to the requester and rewrites the directory entry.

The data of each line is kept in a small internal memory. Acknowledgements that carry a dirty copy are written into that memory before the reply is built. Outgoing messages leave on a single port, at most one per cycle, and each names exactly one destination node.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every line is Uncached with an empty presence vector and zero data. `req_ready` is 1 and `msg_valid` is 0. A reset taken in the middle of a transaction abandons it.
- R2: A read miss (`req_kind`=0) to an Uncached or Shared line sends no coherence message. It replies with the stored data and adds the requester to the presence vector, and the line is left Shared.
- R3: A read miss to an Exclusive line owned by another node sends one fetch (`msg_kind`=1) to the owner. The acknowledged data is written to memory and returned to the requester, and the line becomes Shared with both owner and requester present.
- R4: A write miss (`req_kind`=1) to a Shared line sends one invalidate (`msg_kind`=0) to each present node other than the requester, one per cycle. The line then becomes Exclusive with only the requester present.
- R5: A write miss to an Exclusive line owned by another node sends a fetch-and-invalidate (`msg_kind`=2) to the owner. The returned data is stored and replied, and ownership passes to the requester.
- R6: The data reply (`msg_kind`=3, addressed to the requester) is sent only after every node that was messaged for the request has acknowledged. An acknowledgement may arrive in the same cycle as the next invalidate leaves.
- R7: From the cycle a request is accepted until its reply has been sent, or until a write-back has been absorbed, `req_ready` is 0.
- R8: A write-back (`req_kind`=2) from the owner of an Exclusive line stores `req_data` and returns the line to Uncached with an empty vector. It sends no message.
- R9: A write-back from a node that does not own the line in Exclusive state changes neither data nor directory.
- R10: Coherence messages are never addressed to the requester. A write miss by the node that already owns the line is replied at once without coherence messages. Every message carries the requested line in `msg_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_node | input | NODE_W | Requesting node id |
| req_line | input | LINE_W | Line index |
| req_data | input | DATA_W | Write-back data |
| msg_valid | output | 1 | Outgoing message present |
| msg_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| msg_node | output | NODE_W | Destination node id |
| msg_line | output | LINE_W | Line the message concerns |
| msg_data | output | DATA_W | Reply data (zero otherwise) |
| ack_valid | input | 1 | Acknowledgement present |
| ack_node | input | NODE_W | Acknowledging node id |
| ack_has_data | input | 1 | Acknowledgement carries a line copy |
| ack_data | input | DATA_W | Returned line data |

## Verification
Two functions can fall in the same cycle: issuing the next invalidate of a fan-out, and retiring an acknowledgement for an earlier one. The bench's responder acknowledges each message one cycle after it is seen. On a write miss to a line with three sharers, the acknowledgement of the first invalidate therefore lands while the second is being sent. The bench then checks that every sharer was reached exactly once, and that the reply came only after all acknowledgements had been delivered. It also checks that the reply came with the right data.

// File: rtl/coh_home_pkg.sv
// Shared encodings of the home-node directory controller.
// Assumes: message and request codes are visible at the ports, so their
// values are fixed here and decoded by the requesting and remote nodes.
package coh_home_pkg;

    typedef enum logic [1:0] {
        RK_READ  = 2'd0,
        RK_WRITE = 2'd1,
        RK_WBACK = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        MK_INV       = 2'd0,
        MK_FETCH     = 2'd1,
        MK_FETCH_INV = 2'd2,
        MK_REPLY     = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        DS_UNCACHED = 2'd0,
        DS_SHARED   = 2'd1,
        DS_EXCL     = 2'd2
    } dir_state_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_SEND,
        ST_WAIT,
        ST_REPLY
    } ctl_state_e;

endpackage

// File: rtl/coh_dir_table.sv
// Directory storage: one coherence state and one presence vector per line.
// Assumes: a single read port that is combinational and a single write port
// that is registered. Reset clears every entry to Uncached with no sharers.
module coh_dir_table
    import coh_home_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int NODES  = 4,
    parameter int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    output dir_state_e        rd_state,
    output logic [NODES-1:0]  rd_sharers,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  dir_state_e        wr_state,
    input  logic [NODES-1:0]  wr_sharers
);

    dir_state_e       st_arr [LINES];
    logic [NODES-1:0] sh_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_entry
        // Hold one line's entry; load it when the write port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_arr[g] <= DS_UNCACHED;
                sh_arr[g] <= '0;
            end else if (wr_en && (wr_line == LINE_W'(g))) begin
                st_arr[g] <= wr_state;
                sh_arr[g] <= wr_sharers;
            end
        end
    end

    // Present the entry of the addressed line.
    always_comb begin
        rd_state   = st_arr[rd_line];
        rd_sharers = sh_arr[rd_line];
    end

endmodule

// File: rtl/coh_line_store.sv
// Home memory of the lines: one data word per line.
// Assumes: the read is combinational and the write registered; reset clears
// all words to zero so the starting content is known.
module coh_line_store #(
    parameter int LINES  = 8,
    parameter int DATA_W = 16,
    parameter int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] words [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_word
        // Keep one line's data; overwrite it on a selected write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (wr_en && (wr_line == LINE_W'(g))) begin
                words[g] <= wr_data;
            end
        end
    end

    // Drive the addressed word.
    assign rd_data = words[rd_line];

endmodule

// File: rtl/coh_low_pick.sv
// Finds the lowest set bit of a node vector and returns its index.
// Assumes: NODES is at least 1. The index is meaningless when found is 0.
module coh_low_pick #(
    parameter int NODES = 4,
    parameter int IDX_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic [NODES-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so that the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/coh_home_dir.sv
// Home-node directory controller. Takes one request at a time and looks up
// the directory. Sends point-to-point invalidate or fetch messages, one per
// cycle, and counts the acknowledgements back. It then replies with the line
// data and rewrites the directory entry.
// Assumes: each messaged node acknowledges exactly once. Acknowledgements from
// nodes that are not awaited are dropped. Fetch acknowledgements carry data.
module coh_home_dir
    import coh_home_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int LINES  = 8,
    parameter int DATA_W = 16,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [NODE_W-1:0] req_node,
    input  logic [LINE_W-1:0] req_line,
    input  logic [DATA_W-1:0] req_data,
    output logic              msg_valid,
    output logic [1:0]        msg_kind,
    output logic [NODE_W-1:0] msg_node,
    output logic [LINE_W-1:0] msg_line,
    output logic [DATA_W-1:0] msg_data,
    input  logic              ack_valid,
    input  logic [NODE_W-1:0] ack_node,
    input  logic              ack_has_data,
    input  logic [DATA_W-1:0] ack_data
);

    ctl_state_e        st_q;
    req_kind_e         kind_q;
    logic [NODE_W-1:0] node_q;
    logic [LINE_W-1:0] line_q;
    logic [DATA_W-1:0] data_q;
    logic [NODES-1:0]  psh_q;
    logic [NODES-1:0]  todo_q;
    logic [NODES-1:0]  outst_q;
    msg_kind_e         skind_q;

    dir_state_e        d_state;
    logic [NODES-1:0]  d_sharers;
    logic              dir_we;
    dir_state_e        dir_wstate;
    logic [NODES-1:0]  dir_wsharers;

    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;

    logic              pick_found;
    logic [NODE_W-1:0] pick_idx;

    logic [NODES-1:0]  req_bit;
    logic [NODES-1:0]  send_bit;
    logic [NODES-1:0]  ack_bit;
    logic              ack_hit;
    logic              wb_ok;
    logic [NODES-1:0]  plan_todo;
    msg_kind_e         plan_kind;

    coh_dir_table #(
        .LINES (LINES),
        .NODES (NODES),
        .LINE_W(LINE_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_line   (line_q),
        .rd_state  (d_state),
        .rd_sharers(d_sharers),
        .wr_en     (dir_we),
        .wr_line   (line_q),
        .wr_state  (dir_wstate),
        .wr_sharers(dir_wsharers)
    );

    coh_line_store #(
        .LINES (LINES),
        .DATA_W(DATA_W),
        .LINE_W(LINE_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_line(line_q),
        .rd_data(mem_rdata),
        .wr_en  (mem_we),
        .wr_line(line_q),
        .wr_data(mem_wdata)
    );

    coh_low_pick #(
        .NODES(NODES),
        .IDX_W(NODE_W)
    ) u_pick (
        .vec  (todo_q),
        .found(pick_found),
        .idx  (pick_idx)
    );

    // One-hot masks for the requester, the node being messaged and the acker.
    always_comb begin
        req_bit  = NODES'(1) << node_q;
        ack_hit  = ack_valid && ((st_q == ST_SEND) || (st_q == ST_WAIT))
                   && outst_q[ack_node];
        ack_bit  = ack_hit ? (NODES'(1) << ack_node) : '0;
        send_bit = ((st_q == ST_SEND) && pick_found) ? (NODES'(1) << pick_idx) : '0;
    end

    // Write-back is taken only from the current exclusive owner.
    assign wb_ok = (st_q == ST_PLAN) && (kind_q == RK_WBACK)
                   && (d_state == DS_EXCL) && d_sharers[node_q];

    // Decide which nodes must be messaged, and with which message kind.
    always_comb begin
        plan_todo = '0;
        plan_kind = MK_INV;
        if (kind_q == RK_READ) begin
            if (d_state == DS_EXCL) begin
                plan_todo = d_sharers & ~req_bit;
                plan_kind = MK_FETCH;
            end
        end else if (kind_q == RK_WRITE) begin
            if (d_state == DS_SHARED) begin
                plan_todo = d_sharers & ~req_bit;
                plan_kind = MK_INV;
            end else if (d_state == DS_EXCL) begin
                plan_todo = d_sharers & ~req_bit;
                plan_kind = MK_FETCH_INV;
            end
        end
    end

    // Memory is written by an owner's write-back or by returned dirty data.
    always_comb begin
        mem_we    = wb_ok || (ack_hit && ack_has_data);
        mem_wdata = wb_ok ? data_q : ack_data;
    end

    // Directory is rewritten on a write-back or when the reply leaves.
    always_comb begin
        dir_we       = wb_ok || (st_q == ST_REPLY);
        dir_wstate   = DS_SHARED;
        dir_wsharers = psh_q | req_bit;
        if (wb_ok) begin
            dir_wstate   = DS_UNCACHED;
            dir_wsharers = '0;
        end else if (kind_q == RK_WRITE) begin
            dir_wstate   = DS_EXCL;
            dir_wsharers = req_bit;
        end
    end

    // Main sequencer: accept, plan, send, wait for acknowledgements, reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            kind_q  <= RK_READ;
            node_q  <= '0;
            line_q  <= '0;
            data_q  <= '0;
            psh_q   <= '0;
            todo_q  <= '0;
            skind_q <= MK_INV;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        kind_q <= req_kind_e'(req_kind);
                        node_q <= req_node;
                        line_q <= req_line;
                        data_q <= req_data;
                        st_q   <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    psh_q   <= d_sharers;
                    todo_q  <= plan_todo;
                    skind_q <= plan_kind;
                    st_q    <= (kind_q == RK_WBACK) ? ST_IDLE : ST_SEND;
                end
                ST_SEND: begin
                    todo_q <= todo_q & ~send_bit;
                    if (!pick_found) begin
                        st_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (outst_q == '0) begin
                        st_q <= ST_REPLY;
                    end
                end
                ST_REPLY: begin
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Outstanding set: a bit is set when its message leaves and cleared by its ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= '0;
        end else begin
            outst_q <= (outst_q | send_bit) & ~ack_bit;
        end
    end

    // Drive the request handshake and the single outgoing message port.
    always_comb begin
        req_ready = (st_q == ST_IDLE);
        msg_valid = (st_q == ST_REPLY) || ((st_q == ST_SEND) && pick_found);
        msg_kind  = (st_q == ST_REPLY) ? 2'(MK_REPLY) : 2'(skind_q);
        msg_node  = (st_q == ST_REPLY) ? node_q : pick_idx;
        msg_line  = line_q;
        msg_data  = (st_q == ST_REPLY) ? mem_rdata : '0;
    end

endmodule

// File: rtl/coh_home_dir_chk.sv
// Property checker for coh_home_dir, attached by bind.
// Assumes: it observes the top's ports plus the requester id and the
// outstanding-acknowledgement set, all driven by the sequencer registers.
module coh_home_dir_chk #(
    parameter int NODES  = 4,
    parameter int NODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              msg_valid,
    input logic [1:0]        msg_kind,
    input logic [NODE_W-1:0] msg_node,
    input logic [NODE_W-1:0] cur_node,
    input logic [NODES-1:0]  outst
);

    // R7: an accepted request closes the door on the next cycle.
    a_r7_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R6: no reply while any acknowledgement is still owed.
    a_r6_reply_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_kind == 2'd3)) |-> (outst == '0));

    // R10: coherence messages never target the requester.
    a_r10_no_self_msg: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_kind != 2'd3)) |-> (msg_node != cur_node));

    // R4: each node is messaged at most once per request.
    a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_kind != 2'd3)) |-> !outst[msg_node]);

    // R1: an idle controller sends nothing.
    a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !msg_valid);

endmodule

bind coh_home_dir coh_home_dir_chk #(
    .NODES (NODES),
    .NODE_W(NODE_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .msg_valid(msg_valid),
    .msg_kind (msg_kind),
    .msg_node (msg_node),
    .cur_node (node_q),
    .outst    (outst_q)
);

// File: tb/coh_home_dir_tb_top.sv
// Self-checking bench for coh_home_dir with default parameters
// (4 nodes, 8 lines, 16-bit data).
module coh_home_dir_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_node = '0;
    logic [2:0]  req_line = '0;
    logic [15:0] req_data = '0;
    logic        msg_valid;
    logic [1:0]  msg_kind;
    logic [1:0]  msg_node;
    logic [2:0]  msg_line;
    logic [15:0] msg_data;
    logic        ack_valid = 1'b0;
    logic [1:0]  ack_node = '0;
    logic        ack_has_data = 1'b0;
    logic [15:0] ack_data = '0;

    int checks = 0;
    int errors = 0;
    int acks_sent = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    coh_home_dir dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_node(req_node), .req_line(req_line), .req_data(req_data),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_node(msg_node),
        .msg_line(msg_line), .msg_data(msg_data),
        .ack_valid(ack_valid), .ack_node(ack_node),
        .ack_has_data(ack_has_data), .ack_data(ack_data)
    );

    // Stimulus and expectation: kind, node, line, write-back data,
    // expected message mask, expected message kind, reply data, reply expected.
    typedef struct packed {
        logic [1:0]  k;
        logic [1:0]  n;
        logic [2:0]  l;
        logic [15:0] d;
        logic [3:0]  m;
        logic [1:0]  mk;
        logic [15:0] rd;
        logic        rep;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 2'd0, 3'd1, 16'h0000, 4'h0, 2'd0, 16'h0000, 1'b1}, // R2 uncached read
        '{2'd0, 2'd2, 3'd1, 16'h0000, 4'h0, 2'd0, 16'h0000, 1'b1}, // R2 shared read
        '{2'd0, 2'd3, 3'd1, 16'h0000, 4'h0, 2'd0, 16'h0000, 1'b1}, // R2 third sharer
        '{2'd1, 2'd1, 3'd1, 16'h0000, 4'hD, 2'd0, 16'h0000, 1'b1}, // R4 invalidate fan-out
        '{2'd0, 2'd0, 3'd1, 16'h0000, 4'h2, 2'd1, 16'hF011, 1'b1}, // R3 fetch from owner
        '{2'd1, 2'd0, 3'd1, 16'h0000, 4'h2, 2'd0, 16'hF011, 1'b1}, // R4 requester excluded
        '{2'd1, 2'd3, 3'd1, 16'h0000, 4'h1, 2'd2, 16'hF001, 1'b1}, // R5 fetch-and-invalidate
        '{2'd2, 2'd3, 3'd1, 16'h1234, 4'h0, 2'd0, 16'h0000, 1'b0}, // R8 owner write-back
        '{2'd0, 2'd2, 3'd1, 16'h0000, 4'h0, 2'd0, 16'h1234, 1'b1}, // R8 line now uncached
        '{2'd1, 2'd2, 3'd5, 16'h0000, 4'h0, 2'd0, 16'h0000, 1'b1}, // R2 write to uncached
        '{2'd1, 2'd2, 3'd5, 16'h0000, 4'h0, 2'd0, 16'h0000, 1'b1}, // R10 owner rewrites
        '{2'd2, 2'd1, 3'd5, 16'h9999, 4'h0, 2'd0, 16'h0000, 1'b0}, // R9 stray write-back
        '{2'd0, 2'd0, 3'd5, 16'h0000, 4'h4, 2'd1, 16'hF025, 1'b1}  // R9 still owned by 2
    };

    function automatic string tag_of(int i);
        case (i)
            3, 5:    return "R4";
            4:       return "R3";
            6:       return "R5";
            7, 8:    return "R8";
            10:      return "R10";
            11, 12:  return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Acknowledgement responder: answers each coherence message one cycle later.
    int q [8];
    int qh = 0;
    int qt = 0;
    always @(negedge clk) begin
        ack_valid <= 1'b0;
        if (!rst_n) begin
            qh = 0;
            qt = 0;
        end else begin
            if (qh != qt) begin
                ack_valid    <= 1'b1;
                ack_node     <= 2'(q[qh % 8] & 3);
                ack_has_data <= (q[qh % 8] >> 2) != 0;
                ack_data     <= 16'hF000 | 16'((q[qh % 8] & 3) << 4) | 16'(msg_line);
                qh++;
                acks_sent++;
            end
            if (msg_valid && msg_kind != 2'd3) begin
                q[qt % 8] = int'(msg_node) | ((msg_kind != 2'd0) ? 4 : 0);
                qt++;
            end
        end
    end

    // Issue one request and judge every message it produces.
    task automatic run_vec(vec_t v, string tag);
        logic [3:0]  seen;
        logic [15:0] rdata;
        logic [1:0]  rnode;
        bit got;
        int bad_kind, bad_line, stall_bad, racks, acks0, stray;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        acks0 = acks_sent;
        req_valid = 1'b1; req_kind = v.k; req_node = v.n;
        req_line = v.l; req_data = v.d;
        @(posedge clk); #1;
        req_valid = 1'b0;
        seen = '0; got = 0; bad_kind = 0; bad_line = 0; stall_bad = 0;
        racks = 0; rdata = '0; rnode = '0; stray = 0;
        if (v.rep) begin
            for (int c = 0; c < 30 && !got; c++) begin
                @(negedge clk); #1;
                if (msg_valid) begin
                    if (msg_line != v.l) bad_line++;
                    if (msg_kind == 2'd3) begin
                        got = 1; rdata = msg_data; rnode = msg_node;
                        racks = acks_sent - acks0;
                    end else begin
                        if (seen[msg_node]) bad_kind++;
                        seen[msg_node] = 1'b1;
                        if (msg_kind != v.mk) bad_kind++;
                    end
                end
                if (!got && req_ready) stall_bad++;
            end
            chk(seen == v.m, tag, "message mask", seen, v.m);
            chk(bad_kind == 0, tag, "message kind mismatches", bad_kind, 0);
            chk(bad_line == 0, "R10", "message line mismatches", bad_line, 0);
            chk(got, tag, "reply seen", got, 1);
            chk(rdata == v.rd, tag, "reply data", rdata, v.rd);
            chk(rnode == v.n, tag, "reply node", rnode, v.n);
            chk(racks == $countones(v.m), "R6", "acks delivered before reply",
                racks, $countones(v.m));
            chk(stall_bad == 0, "R7", "ready while pending", stall_bad, 0);
        end else begin
            for (int c = 0; c < 6; c++) begin
                @(negedge clk); #1;
                if (msg_valid) stray++;
            end
            chk(stray == 0, tag, "messages on write-back", stray, 0);
            chk(req_ready == 1'b1, "R7", "ready after write-back", req_ready, 1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(msg_valid == 1'b0, "R1", "message after reset", msg_valid, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VEC[i], tag_of(i));
        end

        // R1: reset in the middle of an invalidation abandons it and clears state.
        run_vec('{2'd0, 2'd1, 3'd3, 16'h0, 4'h0, 2'd0, 16'h0, 1'b1}, "R2");
        @(negedge clk); #1;
        req_valid = 1'b1; req_kind = 2'd1; req_node = 2'd2; req_line = 3'd3;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk); #1;
        chk(req_ready == 1'b0, "R7", "busy before reset", req_ready, 0);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R1", "ready after mid-run reset", req_ready, 1);
        chk(msg_valid == 1'b0, "R1", "message after mid-run reset", msg_valid, 0);
        run_vec('{2'd0, 2'd0, 3'd3, 16'h0, 4'h0, 2'd0, 16'h0, 1'b1}, "R1");
        run_vec('{2'd0, 2'd1, 3'd1, 16'h0, 4'h0, 2'd0, 16'h0, 1'b1}, "R1");

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule